// File: doc/BRIEF.md
# Dual-Lane Programmable Delay Line

This block delays an 8-bit data word by a programmable number of clock periods. The word travels as two independent 4-bit lanes, the lower lane on `data_in[3:0]` and the upper lane on `data_in[7:4]`. Both lanes share one clock, one synchronous reset and one 4-bit delay code. The code sets the input-to-output latency anywhere from 3 to 18 periods.

Each lane shifts its input through a chain of seventeen registers. A tap multiplexer picks one of the stages two through seventeen and loads it into a separate output register. A pin-upper control can hold the upper lane at the full 18-period delay while the lower lane stays programmable. This suits pipelines in which one field needs a fixed maximum alignment and another needs a tunable one.

The delay code and the pin control are registered before they steer the multiplexers. Changing either one only moves the tap point. The data already stored in the chains is left untouched.

Top module: `dual_lane_delay`

## Requirements
- R1: While `rst_n` is low at a rising edge, every chain stage, both output registers and the registered controls are cleared to 0. Afterwards each output shows 0 until the first data captured after reset reaches it.
- R2: The lower lane output `data_out[3:0]` equals `data_in[3:0]` delayed by (registered code + 3) clock periods. Code 0 gives the shortest path of 3 periods, and code 15 gives 18 periods.
- R3: With the registered pin-upper bit at 0, the upper lane output `data_out[7:4]` uses the same delay as the lower lane.
- R4: With the registered pin-upper bit at 1, the upper lane delays `data_in[7:4]` by 18 periods whatever the code is.
- R5: `len_code` and `pin_upper` are captured at a rising edge. A new value first changes which stage loads the output register at the next rising edge.
- R6: Changing the code or the pin-upper bit, even on every cycle, leaves the chain contents unchanged. After any change the output shows exactly the sample held at the newly selected stage.
- R7: The lanes are independent. Bits 3..0 never affect `data_out[7:4]`, and bits 7..4 never affect `data_out[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 8 | Input word; bits 3..0 form the lower lane, bits 7..4 the upper lane |
| len_code | input | 4 | Delay code; the delay is code + 3 periods |
| pin_upper | input | 1 | 1 holds the upper lane at 18 periods |
| data_out | output | 8 | Delayed word, with the same lane split as `data_in` |

## Verification
Four properties are checked on every cycle:
- the upper lane's tap equals the lower lane's tap when pin-upper is off;
- the upper lane's tap sits on the last stage when pin-upper is on;
- at code 0, each lane's output is exactly its input three cycles earlier;
- an output register that was cleared in reset reads zero.

Only the bench scenarios can show three further behaviours:
- the delay is correct for every code from 1 to 15;
- the one-cycle control latency holds;
- chain contents are preserved across rapid code and pin changes.

The bench covers these by comparing both lanes against a history of captured inputs.

// File: rtl/dly_pkg.sv
// Shared constants and types for the dual-lane delay line.
// Assumes a 4-bit delay code; every derived size follows from it.
package dly_pkg;
    localparam int CODE_W    = 4;
    localparam int MAX_DELAY = (1 << CODE_W) + 2;      // 18 periods
    localparam int CHAIN_LEN = MAX_DELAY - 1;          // stages before output reg
    localparam int TAP_OFS   = 2;                      // code 0 taps stage 2
    localparam int SEL_W     = $clog2(CHAIN_LEN + 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef struct packed {
        logic  pin_upper;
        code_t code;
    } ctrl_t;
endpackage

// File: rtl/dly_ctrl_reg.sv
// Captures the delay code and pin-upper control on each rising edge.
// Assumes synchronous active-low reset; reset value is code 0, unpinned.
module dly_ctrl_reg
    import dly_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t code_i,
    input  logic  pin_i,
    output ctrl_t ctrl_q
);
    // Register the control inputs so the tap muxes see stable values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q.code      <= code_i;
            ctrl_q.pin_upper <= pin_i;
        end
    end
endmodule

// File: rtl/dly_tap_select.sv
// Turns the registered controls into a stage index for one lane.
// A pinnable lane selects the last chain stage when pinning is active.
module dly_tap_select
    import dly_pkg::*;
#(
    parameter bit PINNABLE = 1'b0
) (
    input  ctrl_t ctrl,
    output sel_t  sel
);
    generate
        if (PINNABLE) begin : g_pin
            // Pinned lane: full depth, otherwise follow the code.
            always_comb begin
                if (ctrl.pin_upper)
                    sel = sel_t'(CHAIN_LEN);
                else
                    sel = sel_t'(ctrl.code) + sel_t'(TAP_OFS);
            end
        end else begin : g_free
            // Free lane: always follow the code.
            always_comb sel = sel_t'(ctrl.code) + sel_t'(TAP_OFS);
        end
    endgenerate
endmodule

// File: rtl/dly_lane.sv
// One lane: a shift chain of CHAIN_LEN registers, a tap mux over stages
// TAP_OFS..CHAIN_LEN, and an output register. Assumes sel is registered
// upstream and lies within that range.
module dly_lane
    import dly_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  sel_t         sel,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [1:CHAIN_LEN];
    logic [W-1:0] tap;

    // Shift chain: stage 1 takes the input, each later stage its predecessor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 1; k <= CHAIN_LEN; k++) stage[k] <= '0;
        end else begin
            stage[1] <= din;
            for (int k = 2; k <= CHAIN_LEN; k++) stage[k] <= stage[k-1];
        end
    end

    // Tap mux: choose the stage named by sel.
    always_comb begin
        tap = '0;
        for (int k = TAP_OFS; k <= CHAIN_LEN; k++)
            if (sel == sel_t'(k)) tap = stage[k];
    end

    // Output register: the final stage of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= tap;
    end

    // Checker state: edges since reset (saturating) and previous-reset flag.
    logic [2:0] run_cnt;
    logic       seen_edge;
    logic       rst_prev;
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        rst_prev  <= !rst_n;
        if (!rst_n)               run_cnt <= '0;
        else if (run_cnt != 3'd7) run_cnt <= run_cnt + 3'd1;
    end

    // R1
    always @(posedge clk) begin
        if (seen_edge && rst_prev)
            r1_out_cleared_chk: assert (dout == '0);
    end

    // R2
    r2_min_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 3'd3 && $past(sel) == sel_t'(TAP_OFS)) |-> dout == $past(din, 3));
endmodule

// File: rtl/dual_lane_delay.sv
// Top: splits the word into lanes, registers the controls, derives each
// lane's tap and instantiates the lanes. The highest lane can be pinned
// at full depth.
module dual_lane_delay
    import dly_pkg::*;
#(
    parameter int LANE_W  = 4,
    parameter int N_LANES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LANES*LANE_W-1:0] data_in,
    input  logic [CODE_W-1:0]         len_code,
    input  logic                      pin_upper,
    output logic [N_LANES*LANE_W-1:0] data_out
);
    localparam int TOP_LANE = N_LANES - 1;

    ctrl_t ctrl_q;
    sel_t  lane_sel [N_LANES];

    dly_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (len_code),
        .pin_i  (pin_upper),
        .ctrl_q (ctrl_q)
    );

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            dly_tap_select #(.PINNABLE(g == TOP_LANE)) u_sel (
                .ctrl (ctrl_q),
                .sel  (lane_sel[g])
            );
            dly_lane #(.W(LANE_W)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (data_in[g*LANE_W +: LANE_W]),
                .sel   (lane_sel[g]),
                .dout  (data_out[g*LANE_W +: LANE_W])
            );
        end
    endgenerate

    // R3
    r3_lanes_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.pin_upper |-> lane_sel[TOP_LANE] == lane_sel[0]);

    // R4
    r4_pinned_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.pin_upper |-> lane_sel[TOP_LANE] == sel_t'(CHAIN_LEN));
endmodule

// File: tb/test_dual_lane_delay.sv
module test_dual_lane_delay;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] data_in;
    logic [3:0] len_code;
    logic       pin_upper;
    logic [7:0] data_out;

    int n_run  = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;
    string tag_lo = "R2";
    string tag_hi = "R3";

    always #2 clk = ~clk;

    dual_lane_delay i_dual_lane_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .len_code  (len_code),
        .pin_upper (pin_upper),
        .data_out  (data_out)
    );

    // Reference model: captured-input history and registered controls.
    logic [7:0] hist [0:16];
    logic [3:0] m_code;
    logic       m_pin;
    logic [3:0] exp_lo, exp_hi;

    function automatic int lo_idx(input logic [3:0] c);
        return int'(c) + 1;        // stage code+2 holds hist[code+1]
    endfunction

    function automatic int hi_idx(input logic [3:0] c, input logic p);
        return p ? 16 : int'(c) + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k <= 16; k++) hist[k] = '0;
            m_code = '0; m_pin = 1'b0; exp_lo = '0; exp_hi = '0;
        end else begin
            exp_lo = hist[lo_idx(m_code)][3:0];
            exp_hi = hist[hi_idx(m_code, m_pin)][7:4];
            for (int k = 16; k >= 1; k--) hist[k] = hist[k-1];
            hist[0] = data_in;
            m_code = len_code;
            m_pin  = pin_upper;
        end
    end

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: wait past the edge, check both lanes, then drive next inputs.
    task automatic tick(input logic [7:0] d, input logic [3:0] c, input logic p);
        @(posedge clk); #1;
        if (chk_en) begin
            check(tag_lo, data_out[3:0], exp_lo);
            check(tag_hi, data_out[7:4], exp_hi);
        end
        data_in = d; len_code = c; pin_upper = p;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; data_in = 8'hA5; len_code = 4'd9; pin_upper = 1'b1;
        repeat (3) tick(8'($urandom), 4'd9, 1'b1);
        rst_n = 1'b1;
        // R1: reset state and zero-fill after release.
        tag_lo = "R1"; tag_hi = "R1"; chk_en = 1'b1;
        for (int i = 0; i < 20; i++) tick(8'($urandom), 4'd15, 1'b0);
        // R2/R3/R5 sweep, unpinned; first two cycles after change show R5.
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 16; c++) begin
                for (int i = 0; i < 22; i++) begin
                    if (i < 2) begin tag_lo = "R5"; tag_hi = "R5"; end
                    else begin tag_lo = "R2"; tag_hi = (p == 0) ? "R3" : "R4"; end
                    tick(8'($urandom), 4'(c), 1'(p));
                end
            end
        end
        // R6: controls change on random cycles, chain must be intact.
        tag_lo = "R6"; tag_hi = "R6";
        for (int i = 0; i < 400; i++)
            tick(8'($urandom), 4'($urandom), 1'($urandom));
        // R7: lower nibble fixed, upper random, and the reverse.
        tag_lo = "R7"; tag_hi = "R7";
        for (int i = 0; i < 30; i++) tick({4'($urandom), 4'h0}, 4'd5, 1'b0);
        for (int i = 0; i < 30; i++) tick({4'hF, 4'($urandom)}, 4'd0, 1'b1);
        // R1: reset in mid-stream clears the chains.
        rst_n = 1'b0;
        tick(8'hFF, 4'd3, 1'b1);
        rst_n = 1'b1;
        tag_lo = "R1"; tag_hi = "R1";
        for (int i = 0; i < 20; i++) tick(8'($urandom), 4'd15, 1'b1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule